// File: doc/BRIEF.md
# DTMF Tone Burst Synthesiser

This block turns a 4-bit keypad code into a digital dual-tone sample stream. Two free-running reload dividers, one for the low (row) group and one for the high (column) group, each step a 5-bit phase counter. Each counter addresses a 32-step sine, so one tone period is 32 segments. The segment length comes from the divider count for the selected row or column. The two sine samples are added into one signed sample word. The row sample is scaled down first, so the column tone is about 2 dB louder.

A host loads a digit with a one-cycle write strobe. In continuous mode the tone-enable input alone gates the output. In burst mode each write starts a tone interval followed by an equal silent interval. At the end of the silent interval a ready flag rises. When call-progress mode is selected, both intervals are twice as long. A single-tone mode sends only the row tone or only the column tone. The dividers never stop, so a tone starts without any settling time.

Top module: `dtmf_synth`

## Requirements
- R1: Codes map onto the 4x4 keypad grid as follows. Row 0 holds codes 1, 2, 3, 13. Row 1 holds 4, 5, 6, 14. Row 2 holds 7, 8, 9, 15. Row 3 holds 11, 10, 12, 0. Column 0 holds 1, 4, 7, 11. Column 1 holds 2, 5, 8, 10. Column 2 holds 3, 6, 9, 12. Column 3 holds 13, 14, 15, 0.
- R2: The row tone period is exactly 32 times the row divider count. The default counts are 160, 146, 132 and 118 clocks for rows 0 to 3.
- R3: The column tone period is exactly 32 times the column divider count. The default counts are 92, 84, 76 and 68 clocks for columns 0 to 3.
- R4: The column sample at phase k is round(127*sin(2*pi*k/32)). Phase 0 is zero and phase 1 is positive, so the column tone alone peaks at +127 and -127.
- R5: The row sample is the same sine multiplied by 13/16, rounded toward minus infinity. The row tone alone peaks at +103 and -104.
- R6: When the single-tone input is 1, the output carries only the column tone if the column-select input is 1, and only the row tone if it is 0.
- R7: With burst mode off, the output follows the tone-enable input. When tone-enable is low at a clock edge, the output is zero after that edge.
- R8: In burst mode, a write sampled at edge k gives a nonzero tone after edges k+1 to k+L and a zero output after edges k+L+1 to k+2L. The ready flag is 0 before edge k+2L and 1 after it. L is the BURST_CYCLES parameter.
- R9: When call-progress mode is selected, L becomes 2*BURST_CYCLES.
- R10: A write clears the ready flag at the edge that samples it. The ready flag is held at 0 while burst mode is off.
- R11: While reset is asserted, the sample output and the ready flag are 0.
- R12: In dual-tone mode the output is the column sample plus the scaled row sample. It stays within -231..230 and rises above the largest single-tone value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nominally 3.579545 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_i | input | 4 | Keypad code |
| digit_wr_i | input | 1 | One-cycle strobe that loads digit_i and starts a burst |
| tone_en_i | input | 1 | Tone enable for all transmit output |
| burst_en_i | input | 1 | 1 selects timed burst/pause operation |
| cp_mode_i | input | 1 | Call-progress mode, which doubles the burst and pause lengths |
| single_i | input | 1 | 1 selects single-tone output |
| col_sel_i | input | 1 | In single-tone mode, 1 selects the column tone and 0 the row tone |
| sample_o | output | 10 | Signed mixed sample |
| tx_ready_o | output | 1 | Burst and pause are done; ready for the next digit |

## Verification
The bench keeps the default divider counts. With those counts every one of the eight tone periods can be measured exactly, from zero crossing to zero crossing, within a few thousand cycles. It sets BURST_CYCLES to 200, so the 51 ms interval shrinks to 200 clocks. This makes the exact edges of the tone, the silence and the ready flag cheap to reach, in both the normal and the doubled call-progress timing. With the default burst length, one burst alone would exceed the run length.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int unsigned SINE_W   = 8;
  localparam int unsigned OUT_W    = SINE_W + 2;
  localparam int unsigned PHASE_W  = 5;
  localparam int unsigned GROUPS   = 2;   // 0: row (low group), 1: column (high group)
  localparam int unsigned SCALE_MUL = 13; // low group gain numerator
  localparam int unsigned SCALE_SHR = 4;  // low group gain denominator as shift

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_TONE, SEQ_GAP} seq_state_t;

  function automatic logic [1:0] row_of(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13: row_of = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: row_of = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: row_of = 2'd2;
      default:                 row_of = 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] col_of(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11: col_of = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: col_of = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: col_of = 2'd2;
      default:                 col_of = 2'd3;
    endcase
  endfunction

  // magnitude of the first quarter wave, steps 0..8 of 32
  function automatic logic signed [SINE_W-1:0] quarter(input logic [3:0] k);
    case (k)
      4'd0:    quarter = 8'sd0;
      4'd1:    quarter = 8'sd25;
      4'd2:    quarter = 8'sd49;
      4'd3:    quarter = 8'sd71;
      4'd4:    quarter = 8'sd90;
      4'd5:    quarter = 8'sd106;
      4'd6:    quarter = 8'sd117;
      4'd7:    quarter = 8'sd125;
      default: quarter = 8'sd127;
    endcase
  endfunction

  function automatic logic signed [SINE_W-1:0] sine_of(input logic [PHASE_W-1:0] ph);
    logic [4:0] pos;
    logic [4:0] k5;
    logic signed [SINE_W-1:0] mag;
    pos = {1'b0, ph[3:0]};
    k5  = (pos > 5'd8) ? (5'd16 - pos) : pos;
    mag = quarter(k5[3:0]);
    sine_of = ph[4] ? -mag : mag;
  endfunction
endpackage

// File: rtl/dtmf_digit_decode.sv
module dtmf_digit_decode
  import dtmf_pkg::*;
(
  input  logic [3:0] code_i,
  output logic [1:0] row_o,
  output logic [1:0] col_o
);
  always_comb begin
    row_o = row_of(code_i);
    col_o = col_of(code_i);
  end

  // R1: every code selects exactly one grid cell; no two codes share a cell
  always_comb begin
    if ((code_i == 4'd10) && !(row_o == 2'd3 && col_o == 2'd1))
      p_zero_cell_r1: assert (0) else $error("R1 code 10 misplaced");
    if ((code_i == 4'd0) && !(row_o == 2'd3 && col_o == 2'd3))
      p_d_cell_r1: assert (0) else $error("R1 code 0 misplaced");
  end
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter logic [4*DIV_W-1:0] DIVS = {8'd118, 8'd132, 8'd146, 8'd160}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               sel_i,
  output logic signed [SINE_W-1:0] sample_o
);
  logic [DIV_W-1:0]   cnt_q, cnt_d, reload;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               tick;

  always_comb begin
    reload  = DIVS[sel_i*DIV_W +: DIV_W];
    tick    = (cnt_q == '0);
    cnt_d   = tick ? (reload - DIV_W'(1)) : (cnt_q - DIV_W'(1));
    phase_d = tick ? (phase_q + PHASE_W'(1)) : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign sample_o = sine_of(phase_q);

  // R2 R3: the phase advances only on a divider terminal count
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> phase_q == $past(phase_q))
    else $error("R2 phase moved without a tick");
  // R3: terminal counts are never back to back (counts exceed 1)
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick)
    else $error("R3 divider ticked twice in a row");
endmodule

// File: rtl/dtmf_burst_seq.sv
module dtmf_burst_seq
  import dtmf_pkg::*;
#(
  parameter int unsigned BURST_CYCLES = 182557
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic burst_en_i,
  input  logic cp_mode_i,
  output logic window_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(2*BURST_CYCLES + 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             ready_q, ready_d;

  always_comb begin
    len     = cp_mode_i ? CNT_W'(2*BURST_CYCLES) : CNT_W'(BURST_CYCLES);
    state_d = state_q;
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (!burst_en_i) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (wr_i) begin
      state_d = SEQ_TONE;
      cnt_d   = len - CNT_W'(1);
      ready_d = 1'b0;
    end else begin
      case (state_q)
        SEQ_TONE: begin
          if (cnt_q == '0) begin
            state_d = SEQ_GAP;
            cnt_d   = len - CNT_W'(1);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        SEQ_GAP: begin
          if (cnt_q == '0) begin
            state_d = SEQ_IDLE;
            ready_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  assign window_o = (state_q == SEQ_TONE);
  assign ready_o  = ready_q;

  // R8: ready only rises at the end of a pause
  p_ready_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(state_q) == SEQ_GAP)
    else $error("R8 ready rose outside a pause");
  // R10: a write or burst mode off leaves ready low
  p_ready_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i || !burst_en_i) |=> !ready_q)
    else $error("R10 ready not cleared");
  // R9: the interval counter stays below the doubled length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(2*BURST_CYCLES))
    else $error("R9 interval counter out of range");
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter logic [4*DIV_W-1:0] ROW_DIVS = {8'd118, 8'd132, 8'd146, 8'd160},
  parameter logic [4*DIV_W-1:0] COL_DIVS = {8'd68, 8'd76, 8'd84, 8'd92},
  parameter int unsigned BURST_CYCLES = 182557
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              digit_i,
  input  logic                    digit_wr_i,
  input  logic                    tone_en_i,
  input  logic                    burst_en_i,
  input  logic                    cp_mode_i,
  input  logic                    single_i,
  input  logic                    col_sel_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    tx_ready_o
);
  localparam int unsigned MUL_W = OUT_W + 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // digit register
  logic [3:0] code_q, code_d;
  always_comb code_d = digit_wr_i ? digit_i : code_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  logic [1:0] row_idx, col_idx;
  dtmf_digit_decode u_decode (
    .code_i (code_q),
    .row_o  (row_idx),
    .col_o  (col_idx)
  );

  logic [GROUPS-1:0][1:0]   grp_sel;
  logic signed [SINE_W-1:0] grp_smp [GROUPS];
  assign grp_sel = {col_idx, row_idx};

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    localparam logic [4*DIV_W-1:0] G_DIVS = (g == 0) ? ROW_DIVS : COL_DIVS;
    dtmf_tone_gen #(.DIV_W(DIV_W), .DIVS(G_DIVS)) u_tone (
      .clk      (clk),
      .rst_n    (rst_ni),
      .sel_i    (grp_sel[g]),
      .sample_o (grp_smp[g])
    );
  end

  logic window;
  dtmf_burst_seq #(.BURST_CYCLES(BURST_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_i       (digit_wr_i),
    .burst_en_i (burst_en_i),
    .cp_mode_i  (cp_mode_i),
    .window_o   (window),
    .ready_o    (tx_ready_o)
  );

  // mixer
  logic signed [MUL_W-1:0] row_mul;
  logic signed [OUT_W-1:0] row_scl, col_ext, mix, sample_d;
  logic                    gate;
  always_comb begin
    row_mul = $signed({{(MUL_W-SINE_W){grp_smp[0][SINE_W-1]}}, grp_smp[0]})
              * $signed(MUL_W'(SCALE_MUL));
    row_scl = OUT_W'(row_mul >>> SCALE_SHR);
    col_ext = {{(OUT_W-SINE_W){grp_smp[1][SINE_W-1]}}, grp_smp[1]};
    if (single_i) mix = col_sel_i ? col_ext : row_scl;
    else          mix = col_ext + row_scl;
    gate     = tone_en_i && (!burst_en_i || window);
    sample_d = gate ? mix : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= sample_d;
  end

  // R7: tone enable low silences the next sample
  p_gate_zero_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !tone_en_i |=> sample_o == '0)
    else $error("R7 output not silenced");
  // R12: mixed output stays inside the sum of the two peaks
  p_mix_range_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (sample_o <= 230) && (sample_o >= -231))
    else $error("R12 mixed sample out of range");
  // R4 R6: column tone alone stays within its peak
  p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (single_i && col_sel_i) |=> (sample_o <= 127 && sample_o >= -127))
    else $error("R4 column sample out of range");
  // R5 R6: scaled row tone alone stays within its peak
  p_row_range_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (single_i && !col_sel_i) |=> (sample_o <= 103 && sample_o >= -104))
    else $error("R5 row sample out of range");
endmodule

// File: tb/dtmf_synth_bench.sv
module dtmf_synth_bench;
  localparam int BURST = 200;
  localparam int NVEC  = 8;
  // code, column select, period, peak max, peak min
  localparam int V_CODE [NVEC] = '{1, 5, 9, 0, 11, 10, 12, 14};
  localparam int V_COL  [NVEC] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_PER  [NVEC] = '{5120, 4672, 4224, 3776, 2944, 2688, 2432, 2176};
  localparam int V_MAX  [NVEC] = '{103, 103, 103, 103, 127, 127, 127, 127};
  localparam int V_MIN  [NVEC] = '{-104, -104, -104, -104, -127, -127, -127, -127};

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] digit;
  logic digit_wr, tone_en, burst_en, cp_mode, single, col_sel;
  logic signed [9:0] smp;
  logic ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dtmf_synth #(.BURST_CYCLES(BURST)) u_dtmf_synth (
    .clk(clk), .rst_n(rst_n), .digit_i(digit), .digit_wr_i(digit_wr),
    .tone_en_i(tone_en), .burst_en_i(burst_en), .cp_mode_i(cp_mode),
    .single_i(single), .col_sel_i(col_sel), .sample_o(smp), .tx_ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_digit(input int code);
    digit    = 4'(code);
    digit_wr = 1'b1;
    @(negedge clk);
    digit_wr = 1'b0;
  endtask

  task automatic next_cross(output int n, inout int mx, inout int mn);
    int prev;
    n = 0;
    prev = smp;
    forever begin
      @(negedge clk);
      n++;
      if (smp > mx) mx = smp;
      if (smp < mn) mn = smp;
      if (prev <= 0 && smp > 0) break;
      prev = smp;
    end
  endtask

  task automatic run_burst(input bit cp, input string req);
    int len;
    bit seen;
    bit quiet;
    len  = cp ? 2*BURST : BURST;
    seen = 1'b0;
    quiet = 1'b1;
    cp_mode = cp;
    write_digit(1);
    check(ready == 1'b0, "R10 ready cleared by write", ready, 0);
    for (int i = 1; i <= 2*len; i++) begin
      @(negedge clk);
      if (i <= len && smp != 0) seen = 1'b1;
      if (i > len && smp != 0) quiet = 1'b0;
      if (i == 2*len - 1) check(ready == 1'b0, {req, " ready early"}, ready, 0);
      if (i == 2*len)     check(ready == 1'b1, {req, " ready at end"}, ready, 1);
    end
    check(seen,  {req, " tone during burst"}, seen, 1);
    check(quiet, {req, " silence during pause"}, quiet, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int per, mx, mn, dummy;
    bit seen, quiet;
    rst_n = 1'b0; digit = '0; digit_wr = 1'b0; tone_en = 1'b0;
    burst_en = 1'b0; cp_mode = 1'b0; single = 1'b0; col_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(smp == 0, "R11 sample in reset", smp, 0);
    check(ready == 1'b0, "R11 ready in reset", ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R5 R6: single-tone periods and peaks, one vector per grid line
    tone_en = 1'b1;
    single  = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      col_sel = V_COL[v][0];
      write_digit(V_CODE[v]);
      mx = 0; mn = 0;
      next_cross(dummy, mx, mn);
      next_cross(dummy, mx, mn);
      mx = 0; mn = 0;
      next_cross(per, mx, mn);
      check(per == V_PER[v], V_COL[v] != 0 ? "R1/R3 column period" : "R1/R2 row period",
            per, V_PER[v]);
      check(mx == V_MAX[v], V_COL[v] != 0 ? "R4/R6 column peak" : "R5/R6 row peak", mx, V_MAX[v]);
      check(mn == V_MIN[v], V_COL[v] != 0 ? "R4/R6 column trough" : "R5/R6 row trough", mn, V_MIN[v]);
    end

    // R12 dual-tone mix exceeds either tone alone
    single = 1'b0;
    write_digit(5);
    mx = 0; mn = 0;
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (smp > mx) mx = smp;
      if (smp < mn) mn = smp;
    end
    check(mx > 127, "R12 dual peak above single", mx, 128);
    check(mx <= 230 && mn >= -231, "R12 dual range", mx, 230);

    // R7 gating by tone enable in continuous mode
    tone_en = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (smp != 0) quiet = 1'b0;
    end
    check(quiet, "R7 silent with tone off", quiet, 1);
    tone_en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (smp != 0) seen = 1'b1;
    end
    check(seen, "R7 tone with enable on", seen, 1);
    check(ready == 1'b0, "R10 ready low without burst mode", ready, 0);

    // R8 R9 burst and pause timing
    single   = 1'b1;
    col_sel  = 1'b1;
    burst_en = 1'b1;
    run_burst(1'b0, "R8");
    run_burst(1'b1, "R9");

    // R10 burst mode off clears ready
    check(ready == 1'b1, "R10 ready held while idle", ready, 1);
    burst_en = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R10 ready cleared leaving burst mode", ready, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule